// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation field and the function field of a 32-bit load/store instruction into the control lines of a one-cycle datapath. It selects the write-back register, enables register and memory writes, picks the second ALU operand, chooses the kind of immediate extension, flags conditional branches and jumps, and produces a 4-bit ALU operation code. The decoder is purely combinational, so the control settles within the same cycle as the instruction word.

The ALU code comes from two stages. A main stage looks only at the operation field and produces an intermediate operation class. A second stage either maps that class to a fixed ALU code or, for register-register instructions, takes the code from the function field. Any instruction outside the sixteen supported ones produces all-zero outputs, so no architectural state can change. Outputs the datapath does not use for a given instruction are also driven to zero.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: With operation field 0x00 and function field 0x20, 0x22, 0x24, 0x25, 0x26 or 0x2A, `dst_rd_o` and `reg_wr_o` are 1, `alu_op_o` is the low four bits of the function field, and every other output is 0.
- R2: The ALU code values are ADD 4'b0000, SUB 4'b0010, AND 4'b0100, OR 4'b0101, XOR 4'b0110, SLT 4'b1010.
- R3: Operation fields 0x08 (add), 0x0A (set-less-than), 0x0C (and), 0x0D (or), 0x0E (xor) with immediate give `reg_wr_o`=1, `alu_imm_o`=1, `dst_rd_o`=0 and the matching ALU code; `sext_o` is 1 for 0x08 and 0x0A and 0 for the other three.
- R4: Operation field 0x23 (load word) gives `reg_wr_o`, `alu_imm_o`, `sext_o`, `mem_rd_o` and `mem_to_reg_o` at 1, ALU code ADD, and all other outputs 0.
- R5: Operation field 0x2B (store word) gives `mem_wr_o`, `alu_imm_o` and `sext_o` at 1, ALU code ADD, and all other outputs 0.
- R6: Operation field 0x04 gives `br_eq_o`=1 and 0x05 gives `br_ne_o`=1; both give ALU code SUB with `alu_imm_o`=0 and no register or memory enable.
- R7: Operation field 0x02 gives `jump_o`=1 with every other output, including `alu_op_o`, at 0.
- R8: Any other operation field, or operation field 0x00 with any other function field, drives every output to 0.
- R9: Outputs without meaning for an instruction are 0: `dst_rd_o` for store, branches and jump; `sext_o` for branches and jump; `mem_to_reg_o` for all but load word.
- R10: For any operation field other than 0x00, the outputs do not depend on the function field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Operation field of the current instruction |
| funct_i | input | 6 | Function field of the current instruction |
| dst_rd_o | output | 1 | 1 selects the third register field as destination, 0 the second |
| reg_wr_o | output | 1 | Register file write enable |
| sext_o | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_imm_o | output | 1 | 1 feeds the extended immediate to the ALU, 0 the second register |
| br_eq_o | output | 1 | Branch taken when the ALU result is zero |
| br_ne_o | output | 1 | Branch taken when the ALU result is non-zero |
| jump_o | output | 1 | Unconditional jump |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | 1 writes memory data back, 0 the ALU result |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The decoder holds no state, so a wrong internal decision appears at the ports in the same evaluation as the instruction that exposes it, with no later symptom to wait for. A bad operation class shows as a wrong ALU code or a stray extension or operand select, and a missing guard for unsupported encodings shows as a write or branch enable raised on an illegal instruction. The bench therefore applies every one of the 4096 pairs of operation and function field and compares each output against values derived from the requirements, and separately confirms that non-register instructions give the same result for every function field.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam int OPC_W    = 6;
  localparam int FN_W     = 6;
  localparam int ALU_W    = 4;
  localparam int N_RFUNCT = 6;

  // operation field values
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  // function field values accepted for register-register instructions
  localparam logic [N_RFUNCT*FN_W-1:0] RFUNCT_LIST =
    {6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};

  // ALU codes: low bits of the matching function value
  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_AND = 4'b0100;
  localparam logic [ALU_W-1:0] ALU_OR  = 4'b0101;
  localparam logic [ALU_W-1:0] ALU_XOR = 4'b0110;
  localparam logic [ALU_W-1:0] ALU_SLT = 4'b1010;

  typedef enum logic [2:0] {
    AOP_NONE,
    AOP_FUNCT,
    AOP_ADD,
    AOP_SUB,
    AOP_AND,
    AOP_OR,
    AOP_XOR,
    AOP_SLT
  } aop_e;

  typedef struct packed {
    logic dst_rd;
    logic reg_wr;
    logic sext;
    logic alu_imm;
    logic br_eq;
    logic br_ne;
    logic jump;
    logic mem_rd;
    logic mem_wr;
    logic mem_to_reg;
  } ctrl_t;

endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o,
  output aop_e             aop_o,
  output logic             is_rtype_o
);

  always_comb begin
    ctrl_o     = '0;
    aop_o      = AOP_NONE;
    is_rtype_o = 1'b0;
    unique case (opcode_i)
      OPC_RTYPE: begin
        is_rtype_o    = 1'b1;
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_wr = 1'b1;
        aop_o         = AOP_FUNCT;
      end
      OPC_ADDI: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        aop_o          = AOP_ADD;
      end
      OPC_SLTI: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        aop_o          = AOP_SLT;
      end
      OPC_ANDI: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
        aop_o          = AOP_AND;
      end
      OPC_ORI: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
        aop_o          = AOP_OR;
      end
      OPC_XORI: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
        aop_o          = AOP_XOR;
      end
      OPC_LOAD: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.alu_imm    = 1'b1;
        ctrl_o.sext       = 1'b1;
        ctrl_o.mem_rd     = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        aop_o             = AOP_ADD;
      end
      OPC_STORE: begin
        ctrl_o.alu_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
        aop_o          = AOP_ADD;
      end
      OPC_BEQ: begin
        ctrl_o.br_eq = 1'b1;
        aop_o        = AOP_SUB;
      end
      OPC_BNE: begin
        ctrl_o.br_ne = 1'b1;
        aop_o        = AOP_SUB;
      end
      OPC_JMP: begin
        ctrl_o.jump = 1'b1;
      end
      default: begin
        ctrl_o = '0;
        aop_o  = AOP_NONE;
      end
    endcase
  end

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_dec_pkg::*;
(
  input  aop_e             aop_i,
  input  logic [FN_W-1:0]  funct_i,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             funct_ok_o
);

  logic [N_RFUNCT-1:0] hit;

  for (genvar gi = 0; gi < N_RFUNCT; gi++) begin : g_fmatch
    assign hit[gi] = (funct_i == RFUNCT_LIST[gi*FN_W +: FN_W]);
  end

  assign funct_ok_o = |hit;

  always_comb begin
    unique case (aop_i)
      AOP_FUNCT: alu_op_o = funct_ok_o ? funct_i[ALU_W-1:0] : '0;
      AOP_ADD:   alu_op_o = ALU_ADD;
      AOP_SUB:   alu_op_o = ALU_SUB;
      AOP_AND:   alu_op_o = ALU_AND;
      AOP_OR:    alu_op_o = ALU_OR;
      AOP_XOR:   alu_op_o = ALU_XOR;
      AOP_SLT:   alu_op_o = ALU_SLT;
      default:   alu_op_o = '0;
    endcase
  end

endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
  import ctrl_dec_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       dst_rd_o,
  output logic       reg_wr_o,
  output logic       sext_o,
  output logic       alu_imm_o,
  output logic       br_eq_o,
  output logic       br_ne_o,
  output logic       jump_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       mem_to_reg_o,
  output logic [3:0] alu_op_o
);

  ctrl_t            main_ctrl;
  ctrl_t            gated_ctrl;
  aop_e             aop;
  logic             is_rtype;
  logic             funct_ok;
  logic [ALU_W-1:0] alu_code;

  ctrl_main_dec u_main (
    .opcode_i   (opcode_i),
    .ctrl_o     (main_ctrl),
    .aop_o      (aop),
    .is_rtype_o (is_rtype)
  );

  ctrl_alu_dec u_alu (
    .aop_i      (aop),
    .funct_i    (funct_i),
    .alu_op_o   (alu_code),
    .funct_ok_o (funct_ok)
  );

  // an unknown function value on a register-register instruction is quiet
  always_comb begin
    gated_ctrl = main_ctrl;
    if (is_rtype && !funct_ok) begin
      gated_ctrl = '0;
    end
  end

  assign dst_rd_o     = gated_ctrl.dst_rd;
  assign reg_wr_o     = gated_ctrl.reg_wr;
  assign sext_o       = gated_ctrl.sext;
  assign alu_imm_o    = gated_ctrl.alu_imm;
  assign br_eq_o      = gated_ctrl.br_eq;
  assign br_ne_o      = gated_ctrl.br_ne;
  assign jump_o       = gated_ctrl.jump;
  assign mem_rd_o     = gated_ctrl.mem_rd;
  assign mem_wr_o     = gated_ctrl.mem_wr;
  assign mem_to_reg_o = gated_ctrl.mem_to_reg;
  assign alu_op_o     = alu_code;

endmodule

// File: rtl/insn_ctrl_decoder_chk.sv
module insn_ctrl_decoder_chk (
  input logic [5:0] opcode_i,
  input logic [5:0] funct_i,
  input logic       dst_rd_o,
  input logic       reg_wr_o,
  input logic       sext_o,
  input logic       alu_imm_o,
  input logic       br_eq_o,
  input logic       br_ne_o,
  input logic       jump_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       mem_to_reg_o,
  input logic [3:0] alu_op_o
);

  logic known_opc;
  logic any_out;

  always_comb begin
    case (opcode_i)
      6'h00, 6'h02, 6'h04, 6'h05, 6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h23, 6'h2B:
        known_opc = 1'b1;
      default: known_opc = 1'b0;
    endcase
    any_out = dst_rd_o | reg_wr_o | sext_o | alu_imm_o | br_eq_o | br_ne_o |
              jump_o | mem_rd_o | mem_wr_o | mem_to_reg_o | (|alu_op_o);
  end

  always_comb begin
    assert_rd_only_rtype_R1: assert (!dst_rd_o || (opcode_i == 6'h00 && reg_wr_o && !alu_imm_o))
      else $error("destination select outside register-register decode");
    assert_alu_from_funct_R2: assert (!dst_rd_o || alu_op_o == funct_i[3:0])
      else $error("ALU code does not follow function field");
    assert_load_set_R4: assert (!mem_rd_o || (reg_wr_o && mem_to_reg_o && alu_imm_o && sext_o && alu_op_o == 4'b0000))
      else $error("load controls inconsistent");
    assert_store_set_R5: assert (!mem_wr_o || (!reg_wr_o && !mem_rd_o && alu_op_o == 4'b0000))
      else $error("store controls inconsistent");
    assert_branch_sub_R6: assert (!(br_eq_o || br_ne_o) || (alu_op_o == 4'b0010 && !alu_imm_o && !reg_wr_o))
      else $error("branch without subtract");
    assert_flow_onehot_R7: assert ($onehot0({br_eq_o, br_ne_o, jump_o}))
      else $error("more than one control-flow enable");
    assert_unknown_quiet_R8: assert (known_opc || !any_out)
      else $error("unknown operation field drives an output");
    assert_memreg_dc_R9: assert (!mem_to_reg_o || mem_rd_o)
      else $error("memory-to-register without load");
  end

endmodule

bind insn_ctrl_decoder insn_ctrl_decoder_chk u_chk (
  .opcode_i     (opcode_i),
  .funct_i      (funct_i),
  .dst_rd_o     (dst_rd_o),
  .reg_wr_o     (reg_wr_o),
  .sext_o       (sext_o),
  .alu_imm_o    (alu_imm_o),
  .br_eq_o      (br_eq_o),
  .br_ne_o      (br_ne_o),
  .jump_o       (jump_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .mem_to_reg_o (mem_to_reg_o),
  .alu_op_o     (alu_op_o)
);

// File: tb/insn_ctrl_decoder_tb.sv
module insn_ctrl_decoder_tb;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       dst_rd, reg_wr, sext, alu_imm, br_eq, br_ne, jump, mem_rd, mem_wr, mem_to_reg;
  logic [3:0] alu_op;

  int checks;
  int errors;
  bit done;

  insn_ctrl_decoder u_dut (
    .opcode_i     (opcode),
    .funct_i      (funct),
    .dst_rd_o     (dst_rd),
    .reg_wr_o     (reg_wr),
    .sext_o       (sext),
    .alu_imm_o    (alu_imm),
    .br_eq_o      (br_eq),
    .br_ne_o      (br_ne),
    .jump_o       (jump),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .mem_to_reg_o (mem_to_reg),
    .alu_op_o     (alu_op)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected outputs packed as {dst_rd,reg_wr,sext,alu_imm,br_eq,br_ne,jump,mem_rd,mem_wr,mem_to_reg,alu_op[3:0]}
  function automatic logic [13:0] expect_vec(input logic [5:0] op, input logic [5:0] fn);
    logic [9:0] c;
    logic [3:0] a;
    c = '0;
    a = 4'b0000;
    case (op)
      6'h00: if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h26 || fn == 6'h2A) begin
        c = 10'b1100000000;
        a = fn[3:0];
      end
      6'h08: begin c = 10'b0111000000; a = 4'b0000; end
      6'h0A: begin c = 10'b0111000000; a = 4'b1010; end
      6'h0C: begin c = 10'b0101000000; a = 4'b0100; end
      6'h0D: begin c = 10'b0101000000; a = 4'b0101; end
      6'h0E: begin c = 10'b0101000000; a = 4'b0110; end
      6'h23: begin c = 10'b0111000101; a = 4'b0000; end
      6'h2B: begin c = 10'b0011000010; a = 4'b0000; end
      6'h04: begin c = 10'b0000100000; a = 4'b0010; end
      6'h05: begin c = 10'b0000010000; a = 4'b0010; end
      6'h02: begin c = 10'b0000001000; a = 4'b0000; end
      default: begin c = '0; a = '0; end
    endcase
    return {c, a};
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic [5:0] fn, input int field);
    // field 0..9 control bits from dst_rd down, 10 = ALU code
    bit known_fn;
    known_fn = (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h26 || fn == 6'h2A);
    if ((op == 6'h2B || op == 6'h04 || op == 6'h05 || op == 6'h02) && field == 0) return "R9";
    if ((op == 6'h04 || op == 6'h05 || op == 6'h02) && field == 2) return "R9";
    if (op != 6'h23 && field == 9 && op != 6'h00) return "R9";
    case (op)
      6'h00: return known_fn ? (field == 10 ? "R2" : "R1") : "R8";
      6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: return (field == 10) ? "R2" : "R3";
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h04, 6'h05: return "R6";
      6'h02: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s opcode=%02h funct=%02h actual=%0d expected=%0d", req, name, opcode, funct, act, exp);
    end
  endtask

  function automatic logic [13:0] got_vec();
    return {dst_rd, reg_wr, sext, alu_imm, br_eq, br_ne, jump, mem_rd, mem_wr, mem_to_reg, alu_op};
  endfunction

  logic [13:0] ref_at_f0 [64];

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    opcode = 6'h00;
    funct  = 6'h00;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #2;
    // reset-time state: opcode 0 with funct 0 is unsupported, so all quiet (R8)
    chk("R8", "all_outputs_at_start", int'(got_vec()), 0);

    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        @(posedge clk);
        #1;
        opcode = 6'(op);
        funct  = 6'(fn);
        #3;
        begin
          logic [13:0] e;
          logic [13:0] g;
          e = expect_vec(opcode, funct);
          g = got_vec();
          chk(req_of(opcode, funct, 0),  "dst_rd",     int'(g[13]), int'(e[13]));
          chk(req_of(opcode, funct, 1),  "reg_wr",     int'(g[12]), int'(e[12]));
          chk(req_of(opcode, funct, 2),  "sext",       int'(g[11]), int'(e[11]));
          chk(req_of(opcode, funct, 3),  "alu_imm",    int'(g[10]), int'(e[10]));
          chk(req_of(opcode, funct, 4),  "br_eq",      int'(g[9]),  int'(e[9]));
          chk(req_of(opcode, funct, 5),  "br_ne",      int'(g[8]),  int'(e[8]));
          chk(req_of(opcode, funct, 6),  "jump",       int'(g[7]),  int'(e[7]));
          chk(req_of(opcode, funct, 7),  "mem_rd",     int'(g[6]),  int'(e[6]));
          chk(req_of(opcode, funct, 8),  "mem_wr",     int'(g[5]),  int'(e[5]));
          chk(req_of(opcode, funct, 9),  "mem_to_reg", int'(g[4]),  int'(e[4]));
          chk(req_of(opcode, funct, 10), "alu_op",     int'(g[3:0]), int'(e[3:0]));
          // R10: non-register instructions ignore the function field
          if (fn == 0) ref_at_f0[op] = g;
          else if (op != 0) chk("R10", "funct_independence", int'(g), int'(ref_at_f0[op]));
        end
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule